// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block steers operands and interlocks for a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it receives the decoded fields of the instruction waiting in decode: a valid bit, an operation kind, two source specifiers and a destination specifier. It carries that control information down its own copies of the execute, memory and writeback stage registers.

For the instruction in execute, it compares each source operand that the instruction really reads against the destinations of the two older instructions ahead of it. From that comparison it chooses the operand source for each ALU input. Operand A is specifier 1 and operand B is specifier 2. The choices are the register-file value, the ALU result held after execute, or the ALU result or loaded data held after memory. When a load sits in execute and the decode instruction needs its destination, the controller raises one hold that freezes the PC and the fetch/decode register and places a no-op into execute.

A small behavioural register file sits inside the block. It is written from the writeback stage in the first half of the cycle and read by decode in the second half. An instruction three places behind its producer therefore reads the new value directly, with no bypass.

Top module: `hzu_top`

## Requirements
- R1: After reset, every internal stage slot is empty, both operand selects are 0, and the three hold/bubble outputs are low.
- R2: The controller asserts `pc_hold`, `ifid_hold` and `idex_bubble` in the same cycle when all of these hold: execute holds a load (kind 3) with a nonzero destination, and the decode instruction reads that register as a source.
- R3: An interlock lasts exactly one cycle. On the next edge, execute receives a no-op with its write enable cleared. With decode unchanged, the hold drops in the following cycle.
- R4: When the instruction one stage ahead of execute is an ALU operation (kind 1 or 2) writing a source register of the execute instruction, that operand's select is 1.
- R5: When only the instruction two stages ahead writes the source, the select is 3 if that instruction is a load and 2 if it is an ALU operation.
- R6: When both older instructions write the same source register, the newer one wins and the select is 1.
- R7: A producer three instructions ahead needs no bypass. A register-file read of the register being written in that cycle returns the write data, and the select is 0.
- R8: Register 0 reads as zero and is never written. A destination of 0 never causes a nonzero select or a hold.
- R9: Only sources actually read take part in the comparison. Kind 1 reads specifiers 1 and 2. Kinds 2 and 3 read specifier 1 only. Kind 0 and invalid slots read nothing.
- R10: A register-file read port returns the last value written to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_vld | input | 1 | Decode slot holds a real instruction |
| if_opc | input | 2 | Kind: 0 none, 1 ALU reg-reg, 2 ALU immediate, 3 load |
| if_rs1 | input | 5 | Source specifier 1 of the decode instruction |
| if_rs2 | input | 5 | Source specifier 2 of the decode instruction |
| if_rd | input | 5 | Destination specifier of the decode instruction |
| wb_data | input | DATA_W | Value written back by the instruction in writeback |
| rf_rs1_data | output | DATA_W | Register-file value for specifier 1 |
| rf_rs2_data | output | DATA_W | Register-file value for specifier 2 |
| fwd_a_sel | output | 2 | Operand A source: 0 file, 1 post-execute ALU, 2 post-memory ALU, 3 post-memory load |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into execute |

## Verification
The assertions assume the surrounding pipeline honours the hold. While `pc_hold` is high, the next cycle presents the same decode fields again. Under that assumption, a load in the post-execute slot can never feed the execute instruction, and a hold can never last two cycles. The stimulus re-issues every instruction until its step completes without a hold, so it never breaks that contract. It also places unrelated values in unread specifiers and in register 0, so that the gating is tested.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
    localparam int SPEC_W = 5;

    typedef logic [SPEC_W-1:0] spec_t;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_ALU_RR = 2'd1,
        K_ALU_RI = 2'd2,
        K_LOAD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SEL_FILE    = 2'd0,
        SEL_XM_ALU  = 2'd1,
        SEL_MW_ALU  = 2'd2,
        SEL_MW_LOAD = 2'd3
    } opsel_e;

    typedef struct packed {
        logic  vld;
        kind_e kind;
        logic  wen;
        spec_t rs1;
        spec_t rs2;
        spec_t rd;
    } slot_t;

    function automatic logic uses_rs1(slot_t s);
        return s.vld && (s.kind != K_NONE);
    endfunction

    function automatic logic uses_rs2(slot_t s);
        return s.vld && (s.kind == K_ALU_RR);
    endfunction

    function automatic logic produces(slot_t s, spec_t r);
        return s.wen && (s.rd == r) && (r != '0);
    endfunction
endpackage

// File: rtl/hzu_stage_pipe.sv
module hzu_stage_pipe
    import hzu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t dec_slot,
    input  logic  insert_bubble,
    output slot_t idex,
    output slot_t exmem,
    output slot_t memwb
);
    typedef struct packed {
        slot_t idex;
        slot_t exmem;
        slot_t memwb;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.memwb = pipe_q.exmem;
        pipe_d.exmem = pipe_q.idex;
        if (insert_bubble) begin
            pipe_d.idex = '0;
        end else begin
            pipe_d.idex = dec_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign idex  = pipe_q.idex;
    assign exmem = pipe_q.exmem;
    assign memwb = pipe_q.memwb;

    // R3
    bubble_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insert_bubble |=> (!idex.wen && !idex.vld));
endmodule

// File: rtl/hzu_loaduse_det.sv
module hzu_loaduse_det
    import hzu_pkg::*;
(
    input  slot_t dec_slot,
    input  slot_t idex,
    output logic  stall
);
    logic hit_a, hit_b;

    always_comb begin
        hit_a = uses_rs1(dec_slot) && produces(idex, dec_slot.rs1);
        hit_b = uses_rs2(dec_slot) && produces(idex, dec_slot.rs2);
        stall = (idex.kind == K_LOAD) && (hit_a || hit_b);
    end
endmodule

// File: rtl/hzu_opnd_sel.sv
module hzu_opnd_sel
    import hzu_pkg::*;
(
    input  spec_t  src,
    input  logic   used,
    input  slot_t  exmem,
    input  slot_t  memwb,
    output opsel_e sel
);
    always_comb begin
        sel = SEL_FILE;
        if (used) begin
            if (produces(exmem, src) && (exmem.kind != K_LOAD)) begin
                sel = SEL_XM_ALU;
            end else if (produces(memwb, src)) begin
                sel = (memwb.kind == K_LOAD) ? SEL_MW_LOAD : SEL_MW_ALU;
            end
        end
    end
endmodule

// File: rtl/hzu_regfile.sv
module hzu_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    parameter int NRD    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [$clog2(NREGS)-1:0]           wa,
    input  logic [DATA_W-1:0]                  wd,
    input  logic [NRD-1:0][$clog2(NREGS)-1:0]  ra,
    output logic [NRD-1:0][DATA_W-1:0]         rd
);
    localparam int AW = $clog2(NREGS);

    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    always_comb begin
        mem_d = mem_q;
        if (we && (wa != '0)) begin
            mem_d[wa] = wd;
        end
        mem_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rport
        logic [AW-1:0] addr;
        assign addr  = ra[g];
        assign rd[g] = (addr == '0) ? '0
                     : (we && (wa == addr)) ? wd
                     : mem_q[addr];
    end

    // R8
    zero_reg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[0] == '0);
endmodule

// File: rtl/hzu_top.sv
module hzu_top
    import hzu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_vld,
    input  logic [1:0]        if_opc,
    input  logic [4:0]        if_rs1,
    input  logic [4:0]        if_rs2,
    input  logic [4:0]        if_rd,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] rf_rs1_data,
    output logic [DATA_W-1:0] rf_rs2_data,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    localparam int NREGS = 1 << SPEC_W;
    localparam int NOPND = 2;

    slot_t dec_slot, idex, exmem, memwb;
    logic  stall;

    always_comb begin
        dec_slot      = '0;
        dec_slot.vld  = if_vld;
        dec_slot.kind = kind_e'(if_opc);
        dec_slot.rs1  = if_rs1;
        dec_slot.rs2  = if_rs2;
        dec_slot.rd   = if_rd;
        dec_slot.wen  = if_vld && (kind_e'(if_opc) != K_NONE);
    end

    hzu_stage_pipe u_pipe (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_slot      (dec_slot),
        .insert_bubble (stall),
        .idex          (idex),
        .exmem         (exmem),
        .memwb         (memwb)
    );

    hzu_loaduse_det u_det (
        .dec_slot (dec_slot),
        .idex     (idex),
        .stall    (stall)
    );

    spec_t  src_v  [NOPND];
    logic   used_v [NOPND];
    opsel_e sel_v  [NOPND];

    assign src_v[0]  = idex.rs1;
    assign src_v[1]  = idex.rs2;
    assign used_v[0] = uses_rs1(idex);
    assign used_v[1] = uses_rs2(idex);

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        hzu_opnd_sel u_sel (
            .src   (src_v[g]),
            .used  (used_v[g]),
            .exmem (exmem),
            .memwb (memwb),
            .sel   (sel_v[g])
        );
    end

    logic [NOPND-1:0][SPEC_W-1:0] rf_ra;
    logic [NOPND-1:0][DATA_W-1:0] rf_rd;

    assign rf_ra[0] = if_rs1;
    assign rf_ra[1] = if_rs2;

    hzu_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS),
        .NRD    (NOPND)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (memwb.wen),
        .wa    (memwb.rd),
        .wd    (wb_data),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    assign rf_rs1_data = rf_rd[0];
    assign rf_rs2_data = rf_rd[1];
    assign fwd_a_sel   = sel_v[0];
    assign fwd_b_sel   = sel_v[1];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;

    // R2
    hold_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (idex.kind == K_LOAD && idex.wen && idex.rd != '0));

    // R3
    single_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !pc_hold);

    // R4
    no_load_from_xm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exmem.kind == K_LOAD && exmem.wen && exmem.rd != '0
          && uses_rs1(idex) && idex.rs1 == exmem.rd));

    // R8
    zero_src_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'd0) |-> (idex.rs1 != '0));

    // R9
    unread_b_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uses_rs2(idex) |-> (fwd_b_sel == 2'd0));
endmodule

// File: tb/sim_hzu_top.sv
`timescale 1ns/1ps
module sim_hzu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_vld;
    logic [1:0]  if_opc;
    logic [4:0]  if_rs1, if_rs2, if_rd;
    logic [31:0] wb_data;
    logic [31:0] rf_rs1_data, rf_rs2_data;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        pc_hold, ifid_hold, idex_bubble;

    always #2 clk = ~clk;

    hzu_top u0 (
        .clk(clk), .rst_n(rst_n), .if_vld(if_vld), .if_opc(if_opc),
        .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd), .wb_data(wb_data),
        .rf_rs1_data(rf_rs1_data), .rf_rs2_data(rf_rs2_data),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    typedef struct { int vld; int opc; int rs1; int rs2; int rd; } ins_t;

    ins_t hist[$];
    int   ref_rf [32];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   prev_stall = 1'b0;
    bit   done = 1'b0;

    function automatic ins_t mk(int v, int o, int a, int b, int d);
        ins_t t;
        t.vld = v; t.opc = o; t.rs1 = a; t.rs2 = b; t.rd = d;
        return t;
    endfunction

    function automatic bit rd1(ins_t c); return c.vld != 0 && c.opc != 0; endfunction
    function automatic bit rd2(ins_t c); return c.vld != 0 && c.opc == 1; endfunction
    function automatic bit wr(ins_t c, int r);
        return c.vld != 0 && c.opc != 0 && c.rd == r && r != 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int exp_sel(int r, bit used, output string tag);
        ins_t xm = hist[1];
        ins_t mw = hist[2];
        tag = "R7";
        if (!used) begin tag = "R9"; return 0; end
        if (r == 0) begin tag = "R8"; return 0; end
        if (wr(xm, r) && xm.opc != 3) begin
            tag = wr(mw, r) ? "R6" : "R4";
            return 1;
        end
        if (wr(mw, r)) begin tag = "R5"; return (mw.opc == 3) ? 3 : 2; end
        return 0;
    endfunction

    task automatic rf_chk(int r, int act, int wdat);
        int e;
        string t;
        if (r == 0) begin e = 0; t = "R8"; end
        else if (wr(hist[2], r)) begin e = wdat; t = "R7"; end
        else begin e = ref_rf[r]; t = "R10"; end
        chk(t, "rf_read", act, e);
    endtask

    task automatic step(ins_t i);
        ins_t  ix;
        string t;
        int    e;
        bit    st;
        int    wdat;
        wdat    = 1000 + cyc;
        if_vld  = 1'(i.vld);
        if_opc  = 2'(i.opc);
        if_rs1  = 5'(i.rs1);
        if_rs2  = 5'(i.rs2);
        if_rd   = 5'(i.rd);
        wb_data = 32'(wdat);
        @(negedge clk);
        ix = hist[0];
        e = exp_sel(ix.rs1, rd1(ix), t); chk(t, "fwd_a_sel", int'(fwd_a_sel), e);
        e = exp_sel(ix.rs2, rd2(ix), t); chk(t, "fwd_b_sel", int'(fwd_b_sel), e);
        st = (ix.vld != 0 && ix.opc == 3)
             && ((rd1(i) && wr(ix, i.rs1)) || (rd2(i) && wr(ix, i.rs2)));
        t = prev_stall ? "R3" : (st ? "R2" : "R9");
        chk(t, "pc_hold", int'(pc_hold), int'(st));
        chk(t, "ifid_hold", int'(ifid_hold), int'(st));
        chk(t, "idex_bubble", int'(idex_bubble), int'(st));
        rf_chk(i.rs1, int'(rf_rs1_data), wdat);
        rf_chk(i.rs2, int'(rf_rs2_data), wdat);
        @(posedge clk);
        if (wr(hist[2], hist[2].rd)) ref_rf[hist[2].rd] = wdat;
        hist.push_front(st ? mk(0, 0, 0, 0, 0) : i);
        void'(hist.pop_back());
        prev_stall = st;
        cyc++;
        #1;
    endtask

    task automatic issue(ins_t i, output int n);
        n = 0;
        do begin
            step(i);
            n++;
        end while (prev_stall);
    endtask

    initial begin
        int n;
        rst_n = 1'b0; if_vld = 0; if_opc = 0; if_rs1 = 0; if_rs2 = 0; if_rd = 0; wb_data = 0;
        for (int k = 0; k < 32; k++) ref_rf[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fwd_a_sel", int'(fwd_a_sel), 0);
        chk("R1", "fwd_b_sel", int'(fwd_b_sel), 0);
        chk("R1", "pc_hold", int'(pc_hold), 0);
        chk("R1", "idex_bubble", int'(idex_bubble), 0);
        @(posedge clk); #1;
        for (int k = 0; k < 3; k++) hist.push_back(mk(0, 0, 0, 0, 0));

        // no dependence
        issue(mk(1, 1, 2, 3, 1), n);
        issue(mk(1, 2, 4, 9, 5), n);
        issue(mk(1, 1, 6, 7, 8), n);
        issue(mk(1, 2, 10, 11, 9), n);
        // R2 R3: load then immediate use, exactly one extra step
        issue(mk(1, 3, 2, 0, 12), n);
        issue(mk(1, 1, 12, 3, 13), n);
        chk("R3", "load_use_steps", n, 2);
        issue(mk(1, 0, 0, 0, 0), n);
        issue(mk(1, 0, 0, 0, 0), n);
        // R5: load used two later
        issue(mk(1, 3, 2, 0, 14), n);
        issue(mk(1, 2, 1, 0, 15), n);
        issue(mk(1, 1, 3, 14, 16), n);
        chk("R5", "no_hold_steps", n, 1);
        // R7: use three later, through the file
        issue(mk(1, 2, 1, 0, 17), n);
        issue(mk(1, 0, 0, 0, 0), n);
        issue(mk(1, 0, 0, 0, 0), n);
        issue(mk(1, 1, 17, 17, 18), n);
        // R4 R6: back-to-back writers of one register
        issue(mk(1, 1, 1, 2, 7), n);
        issue(mk(1, 2, 7, 0, 7), n);
        issue(mk(1, 1, 7, 7, 19), n);
        // R8: load to register 0 then use of register 0
        issue(mk(1, 3, 1, 0, 0), n);
        issue(mk(1, 1, 0, 0, 20), n);
        chk("R8", "no_hold_steps", n, 1);
        // R9: immediate form and load with unread specifier 2 matching a load
        issue(mk(1, 3, 1, 0, 21), n);
        issue(mk(1, 2, 3, 21, 22), n);
        chk("R9", "no_hold_steps", n, 1);
        issue(mk(1, 3, 1, 0, 23), n);
        issue(mk(1, 3, 4, 23, 24), n);
        chk("R9", "no_hold_steps", n, 1);
        issue(mk(0, 1, 24, 24, 25), n);
        // random mix
        for (int k = 0; k < 400; k++) begin
            ins_t r;
            r = mk(($urandom % 8) != 0, $urandom % 4, $urandom % 6, $urandom % 6, $urandom % 6);
            issue(r, n);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule